// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the column addresses of one SDRAM read or write burst, one address per clock, and returns a read-valid flag with the column tag after the programmed CAS latency. A controller gives it a command strobe with a starting column and a read or write direction. The mode inputs set the burst length, the ordering and the latency. The block tracks the burst until the length runs out, or until a burst-stop, a precharge or a new command ends it. A full-page burst has no length. It steps through every column, wraps from the top column to zero, and keeps going until it is ended. The array itself, row opening and refresh are handled elsewhere.

The control is a three-state machine. CS_IDLE means no burst is running. CS_FIXED runs a burst of 2, 4 or 8 beats. CS_PAGE runs a full-page burst. A command moves the machine from any state into CS_PAGE, into CS_FIXED, or into CS_IDLE for a one-beat burst. CS_FIXED returns to CS_IDLE after its last beat or on stop or precharge. CS_PAGE returns to CS_IDLE only on stop or precharge. The first beat of a command is driven in the command cycle itself. Read beats then pass through a shift pipeline, and the CAS latency picks the tap that drives the read outputs.

Top module: `sdr_colseq_top`

## Requirements
- R1: While reset is held, and in the first cycle after it is released with no command, col_vld and rd_vld are low.
- R2: In a cycle with cmd_go high, col_addr equals cmd_col and col_vld is high in that same cycle, and col_rd equals cmd_rd for every beat of the burst.
- R3: cfg_blen codes are 0 for one beat, 1 for two, 2 for four, 3 for eight and 7 for full page, and codes 4 to 6 act as one beat. A one-beat burst drives exactly one valid column.
- R4: With cfg_ilv low and a length of 2, 4 or 8, beat i has column (start with its low bits cleared) OR ((start + i) mod length), so the burst stays inside its aligned block.
- R5: With cfg_ilv high and a length of 2, 4 or 8, beat i has column (start with its low bits cleared) OR ((start XOR i) mod length).
- R6: A full-page burst always counts up by one from the start column, whatever cfg_ilv is. It wraps from the highest column to 0 and continues with no limit.
- R7: A stop or precharge with no command in the same cycle leaves that cycle's beat valid, and col_vld is low from the next cycle. A stop that comes with cmd_go is ignored.
- R8: A read beat issued in cycle c shows rd_vld high with rd_tag equal to its column in cycle c + L. L is cfg_cl for values 1 to 3, and cfg_cl = 0 is taken as 1. Write beats never raise rd_vld.
- R9: cmd_go during a burst starts the new burst at cmd_col in that cycle. Read beats already issued still come out at their latency, and the new burst's data follow them.
- R10: The length and ordering are captured when the command is accepted, so later changes to cfg_blen or cfg_ilv do not alter a running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_blen | input | 3 | Burst length code (see R3) |
| cfg_ilv | input | 1 | 1 = interleave ordering, 0 = sequential |
| cfg_cl | input | 2 | CAS latency in clocks, 1 to 3 |
| cmd_go | input | 1 | Starts a burst in this cycle |
| cmd_rd | input | 1 | 1 = read burst, 0 = write burst |
| cmd_col | input | CW | Starting column |
| cmd_stop | input | 1 | Burst-stop request |
| cmd_pre | input | 1 | Precharge of the bursting bank |
| col_addr | output | CW | Column of the current beat |
| col_vld | output | 1 | A beat is being issued this cycle |
| col_rd | output | 1 | Current beat belongs to a read |
| rd_vld | output | 1 | Read data for rd_tag is due this cycle |
| rd_tag | output | CW | Column of the read beat that is due |

## Verification
The latency checks assume that cfg_cl holds steady while read beats are in the pipeline. The bench therefore changes the latency only after several idle cycles, once the pipeline has drained. The block-alignment and page-step checks assume that the cycle before a non-command beat belongs to the same burst, which holds because a burst only runs in consecutive cycles. The stimulus changes the length and ordering inputs mid-burst on purpose, but never cfg_cl. It raises stop and precharge only on the last intended beat, or together with a command to show that they are ignored there.

// File: rtl/colseq_pkg.sv
package colseq_pkg;

    typedef enum logic [1:0] {
        CS_IDLE  = 2'd0,
        CS_FIXED = 2'd1,
        CS_PAGE  = 2'd2
    } cs_state_e;

    localparam logic [2:0] BL_ONE   = 3'd0;
    localparam logic [2:0] BL_TWO   = 3'd1;
    localparam logic [2:0] BL_FOUR  = 3'd2;
    localparam logic [2:0] BL_EIGHT = 3'd3;
    localparam logic [2:0] BL_PAGE  = 3'd7;

    // Number of beats minus one for a fixed length code; page and
    // unused codes give zero.
    function automatic logic [3:0] beats_minus1(input logic [2:0] code);
        logic [3:0] r;
        case (code)
            BL_TWO:   r = 4'd1;
            BL_FOUR:  r = 4'd3;
            BL_EIGHT: r = 4'd7;
            default:  r = 4'd0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/colseq_addr_gen.sv
module colseq_addr_gen #(
    parameter int CW = 8
) (
    input  logic [CW-1:0] base,
    input  logic [CW-1:0] beat,
    input  logic          page,
    input  logic          ilv,
    input  logic [3:0]    span_m1,
    output logic [CW-1:0] addr
);

    logic [CW-1:0] low_mask;
    logic [CW-1:0] sum;
    logic [CW-1:0] mixed;

    assign low_mask = CW'(span_m1);
    assign sum      = base + beat;
    assign mixed    = base ^ beat;

    generate
        for (genvar b = 0; b < CW; b++) begin : g_bit
            always_comb begin
                if (page) begin
                    addr[b] = sum[b];
                end else if (!low_mask[b]) begin
                    addr[b] = base[b];
                end else if (ilv) begin
                    addr[b] = mixed[b];
                end else begin
                    addr[b] = sum[b];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/colseq_ctrl.sv
module colseq_ctrl
    import colseq_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_go,
    input  logic          cmd_rd,
    input  logic [CW-1:0] cmd_col,
    input  logic          cmd_stop,
    input  logic          cmd_pre,
    input  logic [2:0]    cfg_blen,
    input  logic          cfg_ilv,
    input  logic [CW-1:0] gen_addr,
    output logic [CW-1:0] base_q,
    output logic [CW-1:0] beat_q,
    output logic          page_q,
    output logic          ilv_q,
    output logic [3:0]    span_q,
    output logic [CW-1:0] col_addr,
    output logic          col_vld,
    output logic          col_rd
);

    cs_state_e     state_q, state_d;
    logic [CW-1:0] base_d, beat_d;
    logic [2:0]    code_q, code_d;
    logic          ilv_d;
    logic          rd_q, rd_d;
    logic          halt;
    logic [3:0]    new_span;
    logic [CW-1:0] blk_mask;

    assign halt     = cmd_stop | cmd_pre;
    assign new_span = beats_minus1(cfg_blen);
    assign span_q   = beats_minus1(code_q);
    assign page_q   = (code_q == BL_PAGE);
    assign blk_mask = CW'(span_q);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        base_d  = base_q;
        beat_d  = beat_q;
        code_d  = code_q;
        ilv_d   = ilv_q;
        rd_d    = rd_q;
        if (cmd_go) begin
            base_d = cmd_col;
            beat_d = CW'(1);
            code_d = cfg_blen;
            ilv_d  = cfg_ilv;
            rd_d   = cmd_rd;
            if (cfg_blen == BL_PAGE) begin
                state_d = CS_PAGE;
            end else if (new_span == 4'd0) begin
                state_d = CS_IDLE;
            end else begin
                state_d = CS_FIXED;
            end
        end else begin
            unique case (state_q)
                CS_IDLE: begin
                    state_d = CS_IDLE;
                end
                CS_FIXED: begin
                    beat_d = beat_q + CW'(1);
                    if (halt || (beat_q == blk_mask)) begin
                        state_d = CS_IDLE;
                    end
                end
                CS_PAGE: begin
                    beat_d = beat_q + CW'(1);
                    if (halt) begin
                        state_d = CS_IDLE;
                    end
                end
                default: begin
                    state_d = CS_IDLE;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CS_IDLE;
            base_q  <= '0;
            beat_q  <= '0;
            code_q  <= BL_ONE;
            ilv_q   <= 1'b0;
            rd_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            base_q  <= base_d;
            beat_q  <= beat_d;
            code_q  <= code_d;
            ilv_q   <= ilv_d;
            rd_q    <= rd_d;
        end
    end

    // Outputs
    always_comb begin
        col_addr = '0;
        col_vld  = 1'b0;
        col_rd   = 1'b0;
        if (cmd_go) begin
            col_addr = cmd_col;
            col_vld  = 1'b1;
            col_rd   = cmd_rd;
        end else if (state_q != CS_IDLE) begin
            col_addr = gen_addr;
            col_vld  = 1'b1;
            col_rd   = rd_q;
        end
    end

    // R3
    single_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_go && (cfg_blen != BL_PAGE) && (new_span == 4'd0)) |=> (state_q == CS_IDLE));

    // R7
    halt_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_go && (cmd_stop || cmd_pre)) |=> (state_q == CS_IDLE));

    // R6
    page_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_go && (state_q == CS_PAGE)) |-> (col_addr == $past(col_addr) + CW'(1)));

    // R4
    block_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_go && (state_q == CS_FIXED))
            |-> ((col_addr & ~blk_mask) == ($past(col_addr) & ~blk_mask)));

endmodule

// File: rtl/colseq_lat_pipe.sv
module colseq_lat_pipe #(
    parameter int CW     = 8,
    parameter int MAX_CL = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic [CW-1:0] in_tag,
    input  logic [1:0]    cl_sel,
    output logic          out_vld,
    output logic [CW-1:0] out_tag
);

    localparam int IW = (MAX_CL > 1) ? $clog2(MAX_CL) : 1;

    logic [MAX_CL-1:0]         vld_q;
    logic [MAX_CL-1:0][CW-1:0] tag_q;
    logic [1:0]                cl_eff;
    logic [IW-1:0]             idx;

    always_comb begin
        cl_eff = (cl_sel == 2'd0) ? 2'd1 : cl_sel;
        if (int'(cl_eff) > MAX_CL) begin
            cl_eff = 2'(MAX_CL);
        end
        idx = IW'(cl_eff - 2'd1);
    end

    generate
        if (MAX_CL == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_q <= '0;
                    tag_q <= '0;
                end else begin
                    vld_q[0] <= in_vld;
                    tag_q[0] <= in_tag;
                end
            end
        end else begin : g_shift
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_q <= '0;
                    tag_q <= '0;
                end else begin
                    vld_q <= {vld_q[MAX_CL-2:0], in_vld};
                    tag_q <= {tag_q[MAX_CL-2:0], in_tag};
                end
            end
        end
    endgenerate

    assign out_vld = vld_q[idx];
    assign out_tag = tag_q[idx];

    // R8
    lat_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (cl_eff == 2'd1))
            |-> ((out_vld == $past(in_vld)) && (!out_vld || (out_tag == $past(in_tag)))));

    // R8
    lat_three_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && $past(rst_n, 3) && (cl_eff == 2'd3))
            |-> (out_vld == $past(in_vld, 3)));

endmodule

// File: rtl/sdr_colseq_top.sv
module sdr_colseq_top #(
    parameter int CW     = 8,
    parameter int MAX_CL = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    cfg_blen,
    input  logic          cfg_ilv,
    input  logic [1:0]    cfg_cl,
    input  logic          cmd_go,
    input  logic          cmd_rd,
    input  logic [CW-1:0] cmd_col,
    input  logic          cmd_stop,
    input  logic          cmd_pre,
    output logic [CW-1:0] col_addr,
    output logic          col_vld,
    output logic          col_rd,
    output logic          rd_vld,
    output logic [CW-1:0] rd_tag
);

    logic [CW-1:0] base_q;
    logic [CW-1:0] beat_q;
    logic          page_q;
    logic          ilv_q;
    logic [3:0]    span_q;
    logic [CW-1:0] gen_addr;

    colseq_ctrl #(.CW(CW)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_go   (cmd_go),
        .cmd_rd   (cmd_rd),
        .cmd_col  (cmd_col),
        .cmd_stop (cmd_stop),
        .cmd_pre  (cmd_pre),
        .cfg_blen (cfg_blen),
        .cfg_ilv  (cfg_ilv),
        .gen_addr (gen_addr),
        .base_q   (base_q),
        .beat_q   (beat_q),
        .page_q   (page_q),
        .ilv_q    (ilv_q),
        .span_q   (span_q),
        .col_addr (col_addr),
        .col_vld  (col_vld),
        .col_rd   (col_rd)
    );

    colseq_addr_gen #(.CW(CW)) addr_i (
        .base    (base_q),
        .beat    (beat_q),
        .page    (page_q),
        .ilv     (ilv_q),
        .span_m1 (span_q),
        .addr    (gen_addr)
    );

    colseq_lat_pipe #(.CW(CW), .MAX_CL(MAX_CL)) pipe_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (col_vld & col_rd),
        .in_tag  (col_addr),
        .cl_sel  (cfg_cl),
        .out_vld (rd_vld),
        .out_tag (rd_tag)
    );

    // R2
    go_same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_go |-> (col_vld && (col_addr == cmd_col) && (col_rd == cmd_rd)));

endmodule

// File: tb/sdr_colseq_top_tb_top.sv
`timescale 1ns/100ps
module sdr_colseq_top_tb_top;

    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    cfg_blen = 3'd2;
    logic          cfg_ilv = 1'b0;
    logic [1:0]    cfg_cl = 2'd2;
    logic          cmd_go = 1'b0;
    logic          cmd_rd = 1'b0;
    logic [CW-1:0] cmd_col = '0;
    logic          cmd_stop = 1'b0;
    logic          cmd_pre = 1'b0;
    logic [CW-1:0] col_addr;
    logic          col_vld;
    logic          col_rd;
    logic          rd_vld;
    logic [CW-1:0] rd_tag;

    always #2 clk = ~clk;

    sdr_colseq_top #(.CW(CW), .MAX_CL(3)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_blen(cfg_blen), .cfg_ilv(cfg_ilv),
        .cfg_cl(cfg_cl), .cmd_go(cmd_go), .cmd_rd(cmd_rd), .cmd_col(cmd_col),
        .cmd_stop(cmd_stop), .cmd_pre(cmd_pre), .col_addr(col_addr),
        .col_vld(col_vld), .col_rd(col_rd), .rd_vld(rd_vld), .rd_tag(rd_tag)
    );

    int    checks = 0;
    int    fails = 0;
    int    cyc = 0;
    bit    done = 1'b0;

    int    col_exp[$];
    bit    dir_exp[$];
    string col_req[$];
    int    rd_exp[$];
    int    rd_due[$];
    string rd_req[$];

    always @(posedge clk) cyc++;

    function automatic int len_of(input logic [2:0] c);
        case (c)
            3'd1: return 2;
            3'd2: return 4;
            3'd3: return 8;
            default: return 1;
        endcase
    endfunction

    function automatic int exp_col(input int start, input int i, input logic [2:0] c, input bit ilv);
        int m;
        int hi;
        if (c == 3'd7) return (start + i) % 256;
        m = len_of(c) - 1;
        hi = start & ~m;
        if (ilv) return hi | ((start ^ i) & m);
        return hi | ((start + i) & m);
    endfunction

    function automatic int eff_cl(input logic [1:0] c);
        return (c == 2'd0) ? 1 : int'(c);
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            tick();
            cmd_go = 1'b0;
            cmd_stop = 1'b0;
            cmd_pre = 1'b0;
        end
    endtask

    // term: 0 natural/interrupt, 1 stop on last beat, 2 precharge on last beat
    task automatic issue(input int col, input bit rd, input int nbeats, input int term,
                         input bit stop_first, input bit flip, input string req);
        logic [2:0] code;
        bit         ilv;
        int         cl;
        code = cfg_blen;
        ilv  = cfg_ilv;
        cl   = eff_cl(cfg_cl);
        for (int i = 0; i < nbeats; i++) begin
            tick();
            cmd_go   = (i == 0);
            cmd_col  = CW'(col);
            cmd_rd   = rd;
            cmd_stop = ((term == 1) && (i == nbeats - 1)) || (stop_first && (i == 0));
            cmd_pre  = (term == 2) && (i == nbeats - 1);
            if (flip && (i == 1)) begin
                cfg_blen = 3'd0;
                cfg_ilv  = ~ilv;
            end
            col_exp.push_back(exp_col(col, i, code, ilv));
            dir_exp.push_back(rd);
            col_req.push_back(req);
            if (rd) begin
                rd_exp.push_back(exp_col(col, i, code, ilv));
                rd_due.push_back(cyc + cl);
                rd_req.push_back(req);
            end
        end
        if (flip) begin
            cfg_blen = code;
            cfg_ilv  = ilv;
        end
    endtask

    // Monitor
    always @(negedge clk) begin
        int    e;
        int    d;
        bit    dr;
        string r;
        if (rst_n && !done) begin
            if (col_exp.size() > 0) begin
                e = col_exp.pop_front();
                dr = dir_exp.pop_front();
                r = col_req.pop_front();
                checks++;
                if (!col_vld || (int'(col_addr) != e) || (col_rd != dr)) begin
                    fails++;
                    $display("FAIL %s column: actual vld=%0d addr=%0d rd=%0d expected vld=1 addr=%0d rd=%0d",
                             r, col_vld, col_addr, col_rd, e, dr);
                end
            end else if (col_vld) begin
                checks++;
                fails++;
                $display("FAIL R7 stray beat: actual vld=1 addr=%0d expected vld=0", col_addr);
            end
            if ((rd_due.size() > 0) && (rd_due[0] <= cyc)) begin
                e = rd_exp.pop_front();
                d = rd_due.pop_front();
                r = rd_req.pop_front();
                checks++;
                if (!rd_vld || (int'(rd_tag) != e) || (d != cyc)) begin
                    fails++;
                    $display("FAIL %s read data: actual vld=%0d tag=%0d cycle=%0d expected vld=1 tag=%0d cycle=%0d",
                             r, rd_vld, rd_tag, cyc, e, d);
                end
            end else if (rd_vld) begin
                checks++;
                fails++;
                $display("FAIL R8 stray read: actual vld=1 tag=%0d expected vld=0", rd_tag);
            end
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL R1 watchdog: actual still running expected finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (col_vld || rd_vld) begin
            fails++;
            $display("FAIL R1 in reset: actual col_vld=%0d rd_vld=%0d expected 0 0", col_vld, rd_vld);
        end
        tick();
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (col_vld || rd_vld) begin
            fails++;
            $display("FAIL R1 after reset: actual col_vld=%0d rd_vld=%0d expected 0 0", col_vld, rd_vld);
        end
        idle(2);

        // R4 sequential four-beat read, wraps inside block 4..7
        cfg_blen = 3'd2; cfg_ilv = 1'b0; cfg_cl = 2'd2;
        issue(6, 1'b1, 4, 0, 1'b0, 1'b0, "R4");
        idle(6);

        // R5 interleave eight-beat read
        cfg_blen = 3'd3; cfg_ilv = 1'b1;
        issue(5, 1'b1, 8, 0, 1'b0, 1'b0, "R5");
        idle(6);

        // R3 single beat, code 0 and unused code 5
        cfg_blen = 3'd0;
        issue(9, 1'b1, 1, 0, 1'b0, 1'b0, "R3");
        idle(6);
        cfg_blen = 3'd5;
        issue(12, 1'b0, 1, 0, 1'b0, 1'b0, "R3");
        idle(6);

        // R4 two-beat write, R2 direction
        cfg_blen = 3'd1; cfg_ilv = 1'b0;
        issue(3, 1'b0, 2, 0, 1'b0, 1'b0, "R2");
        idle(6);

        // R6 full page read across the top column, ended by stop, latency 1
        cfg_cl = 2'd1; cfg_blen = 3'd7;
        issue(250, 1'b1, 10, 1, 1'b0, 1'b0, "R6");
        idle(6);

        // R6 full page with interleave selected, ended by precharge (R7)
        cfg_ilv = 1'b1;
        issue(100, 1'b0, 5, 2, 1'b0, 1'b0, "R7");
        idle(6);

        // R9 interrupt an eight-beat read after three beats, latency 3
        cfg_cl = 2'd3; cfg_blen = 3'd3; cfg_ilv = 1'b0;
        issue(16, 1'b1, 3, 0, 1'b0, 1'b0, "R9");
        cfg_blen = 3'd2;
        issue(40, 1'b1, 4, 0, 1'b0, 1'b0, "R9");
        idle(6);

        // R9 a command on every clock, then a full eight-beat burst
        cfg_blen = 3'd3;
        issue(60, 1'b1, 1, 0, 1'b0, 1'b0, "R9");
        issue(70, 1'b1, 1, 0, 1'b0, 1'b0, "R9");
        issue(80, 1'b1, 1, 0, 1'b0, 1'b0, "R9");
        issue(90, 1'b1, 8, 0, 1'b0, 1'b0, "R9");
        idle(6);

        // R7 stop together with the command is ignored
        cfg_blen = 3'd2;
        issue(20, 1'b1, 4, 0, 1'b1, 1'b0, "R7");
        idle(6);

        // R10 mode inputs change during the burst
        cfg_blen = 3'd3; cfg_ilv = 1'b1;
        issue(33, 1'b1, 8, 0, 1'b0, 1'b1, "R10");
        idle(6);

        // R8 latency code 0 acts as 1
        cfg_cl = 2'd0; cfg_blen = 3'd1; cfg_ilv = 1'b0;
        issue(7, 1'b1, 2, 0, 1'b0, 1'b0, "R8");
        idle(8);

        done = 1'b1;
        checks++;
        if ((col_exp.size() != 0) || (rd_due.size() != 0)) begin
            fails++;
            $display("FAIL R8 drain: actual pending col=%0d rd=%0d expected 0 0",
                     col_exp.size(), rd_due.size());
        end
        finish_run();
    end

endmodule